// File: doc/BRIEF.md
# Temperature Alert Conditioner

This block turns a stream of periodic temperature samples from up to eight sensors into a single alert line that can be trusted as a control signal. Each sample carries a channel index. It first passes a plausibility gate that discards physically impossible jumps. It is then smoothed by a short moving average and compared against that channel's own trip and clear levels. The per-channel result drives a small hysteresis state machine. The global alert is built from the channel states and shaped by minimum on and off dwell times and a re-issue interval.

Samples are signed 16-bit values in units of 1/16 °C. The block never stalls its input, and it accepts one sample per cycle. Thresholds are static configuration inputs, one pair per channel. A sticky bit per channel records which sensors have tripped until software clears it. A per-channel counter records how many samples the plausibility gate has thrown away.

Top module: `temp_alert_cond`

## Requirements
- R1: Every channel is compared only against its own trip and clear levels (slice `c` of `trip_thr` and `clr_thr`, 16 bits each, signed), so two channels with the same filtered value can be in different states.
- R2: The filtered value of a channel is the average of its last 4 accepted samples, truncated toward zero. Before 4 samples have been accepted, it is the average of those received so far. A channel with no accepted sample never trips.
- R3: A channel enters the tripped state when its filtered value is at or above its trip level. It leaves that state only when the value is at or below its clear level. Values between the two levels hold the current state.
- R4: A channel stays tripped for at least `MIN_ON` cycles after it trips. Once `alert` rises, it stays high for more than `MIN_ON` cycles.
- R5: After `alert` falls, it stays low for more than `MIN_OFF` cycles, even if a channel trips again at once.
- R6: Two rising edges of `alert` are at least `REISSUE`+1 cycles apart.
- R7: A sample whose absolute difference from the channel's last accepted sample exceeds `STEP_LIM` is rejected and has no effect on the average. A difference of exactly `STEP_LIM` is accepted. The first sample of a channel is always accepted.
- R8: Each rejected sample raises `rej_pulse` for one cycle and adds one to that channel's saturating counter in `rej_count` (slice `c`, `RCW` bits).
- R9: A channel's bit in `chan_sticky` is set when that channel trips. It is cleared by a 1 on the same bit of `sticky_clr`, and a trip in the same cycle wins over the clear.
- R10: After reset, `alert`, `chan_trip`, `chan_sticky`, `rej_pulse` and `rej_count` are all zero. `alert` rises only while some channel is tripped. When no dwell or rate limit holds it back, it rises one cycle after the channel trips.
- R11: `s_ready` is high whenever the block is out of reset. A sample is taken on a cycle with `s_valid` and `s_ready` both high, and it goes to the channel given by `s_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample can be taken |
| s_chan | input | $clog2(NCH) | Channel index of the sample |
| s_data | input | DW | Signed sample, 1/16 °C |
| trip_thr | input | NCH*DW | Per-channel trip levels, channel c at bits c*DW |
| clr_thr | input | NCH*DW | Per-channel clear levels, channel c at bits c*DW |
| sticky_clr | input | NCH | Clear request for sticky bits |
| alert | output | 1 | Conditioned global alert |
| chan_trip | output | NCH | Per-channel tripped state |
| chan_sticky | output | NCH | Per-channel sticky trip record |
| rej_pulse | output | 1 | One-cycle pulse per rejected sample |
| rej_count | output | NCH*RCW | Per-channel rejected-sample counters |

## Verification
The bench measures exact cycle gaps on `alert`. It checks the on-dwell after a rise, the hold-off after a fall, and the re-issue interval. A design that counted one cycle short, or restarted a timer at the wrong event, would shift one of these gaps and be caught. Partial-window averaging is checked with a sample that sits exactly on the trip level, and a sequence that crosses it only on the fourth sample. A design that divided by four too early would trip late or not at all. Rejection is checked in both directions and at the exact limit. In one case the rejected value would have lifted the average onto the trip level, so a design that let it through would trip a channel that must stay quiet. Hysteresis is checked with values held between the two levels and one that lands exactly on the clear level.

// File: rtl/temp_alert_cond.sv
module temp_alert_cond #(
  parameter int NCH      = 8,
  parameter int DW       = 16,
  parameter int RCW      = 8,
  parameter int MIN_ON   = 64,
  parameter int MIN_OFF  = 64,
  parameter int REISSUE  = 256,
  parameter int STEP_LIM = 160
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [$clog2(NCH)-1:0]   s_chan,
  input  logic signed [DW-1:0]     s_data,
  input  logic [NCH*DW-1:0]        trip_thr,
  input  logic [NCH*DW-1:0]        clr_thr,
  input  logic [NCH-1:0]           sticky_clr,
  output logic                     alert,
  output logic [NCH-1:0]           chan_trip,
  output logic [NCH-1:0]           chan_sticky,
  output logic                     rej_pulse,
  output logic [NCH*RCW-1:0]       rej_count
);
  localparam int CMAX0 = (MIN_ON > MIN_OFF) ? MIN_ON : MIN_OFF;
  localparam int CMAX  = (CMAX0 > REISSUE) ? CMAX0 : REISSUE;
  localparam int TW    = $clog2(CMAX + 2);
  localparam logic [TW-1:0] T_SAT = TW'(CMAX);
  localparam logic [TW-1:0] ON_L  = TW'(MIN_ON);
  localparam logic [TW-1:0] OFF_L = TW'(MIN_OFF);
  localparam logic [TW-1:0] RI_L  = TW'(REISSUE);
  localparam logic [TW-1:0] SH_SAT = TW'(CMAX + 1);
  localparam logic [DW:0]   STEP_L = (DW+1)'(STEP_LIM);
  localparam logic [RCW-1:0] R_SAT = '1;

  logic signed [DW-1:0] hist [NCH][3];
  logic signed [DW-1:0] filt [NCH];
  logic [2:0]           nsamp [NCH];
  logic [TW-1:0]        on_cnt [NCH];
  logic [RCW-1:0]       rej [NCH];
  logic [TW-1:0]        t_rise, t_fall;

  assign s_ready = rst_n;
  wire take = s_valid & s_ready;

  // incoming sample: plausibility and running average
  wire  [2:0]           n_in  = nsamp[s_chan];
  wire  signed [DW-1:0] last  = filt_last(s_chan);
  logic signed [DW:0]   dstep;
  logic [DW:0]          dmag;
  logic signed [DW+1:0] sum, quot;
  logic                 bad;

  function automatic logic signed [DW-1:0] filt_last(input logic [$clog2(NCH)-1:0] ch);
    return hist[ch][0];
  endfunction

  always_comb begin
    dstep = {s_data[DW-1], s_data} - {last[DW-1], last};
    dmag  = dstep[DW] ? DW'(0) - dstep : dstep;
    bad   = (n_in != 3'd0) && (dmag > STEP_L);
    sum   = (DW+2)'(s_data)
          + ((n_in >= 3'd1) ? (DW+2)'(hist[s_chan][0]) : '0)
          + ((n_in >= 3'd2) ? (DW+2)'(hist[s_chan][1]) : '0)
          + ((n_in >= 3'd3) ? (DW+2)'(hist[s_chan][2]) : '0);
    case (n_in)
      3'd0:    quot = sum;
      3'd1:    quot = sum / (DW+2)'(2);
      3'd2:    quot = sum / (DW+2)'(3);
      default: quot = sum / (DW+2)'(4);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_pulse <= 1'b0;
      chan_trip <= '0;
      chan_sticky <= '0;
      for (int c = 0; c < NCH; c++) begin
        for (int j = 0; j < 3; j++) hist[c][j] <= '0;
        filt[c]   <= '0;
        nsamp[c]  <= '0;
        on_cnt[c] <= '0;
        rej[c]    <= '0;
      end
    end else begin
      rej_pulse <= take & bad;
      for (int c = 0; c < NCH; c++) begin
        if (take && s_chan == c) begin
          if (bad) begin
            if (rej[c] != R_SAT) rej[c] <= rej[c] + 1'b1;
          end else begin
            hist[c][0] <= s_data;
            hist[c][1] <= hist[c][0];
            hist[c][2] <= hist[c][1];
            filt[c]    <= quot[DW-1:0];
            if (nsamp[c] != 3'd4) nsamp[c] <= nsamp[c] + 3'd1;
          end
        end
        chan_sticky[c] <= chan_sticky[c] & ~sticky_clr[c];
        if (!chan_trip[c]) begin
          if (nsamp[c] != 3'd0 && filt[c] >= $signed(trip_thr[c*DW +: DW])) begin
            chan_trip[c]   <= 1'b1;
            chan_sticky[c] <= 1'b1;
            on_cnt[c]      <= '0;
          end
        end else begin
          if (on_cnt[c] != ON_L) on_cnt[c] <= on_cnt[c] + 1'b1;
          if (on_cnt[c] >= ON_L && filt[c] <= $signed(clr_thr[c*DW +: DW]))
            chan_trip[c] <= 1'b0;
        end
      end
    end
  end

  // global alert: dwell and re-issue shaping
  wire raw = |chan_trip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert  <= 1'b0;
      t_rise <= T_SAT;
      t_fall <= T_SAT;
    end else begin
      if (t_rise != T_SAT) t_rise <= t_rise + 1'b1;
      if (t_fall != T_SAT) t_fall <= t_fall + 1'b1;
      if (!alert && raw && t_fall >= OFF_L && t_rise >= RI_L) begin
        alert  <= 1'b1;
        t_rise <= '0;
      end else if (alert && !raw && t_rise >= ON_L) begin
        alert  <= 1'b0;
        t_fall <= '0;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign rej_count[c*RCW +: RCW] = rej[c];
  end

  // independent watch counters for the output timing checks
  logic          a_d;
  logic [TW-1:0] hi_len, lo_len, rise_gap;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_d <= 1'b0; hi_len <= '0; lo_len <= SH_SAT; rise_gap <= SH_SAT;
    end else begin
      a_d      <= alert;
      hi_len   <= alert ? ((hi_len == SH_SAT) ? hi_len : hi_len + 1'b1) : '0;
      lo_len   <= !alert ? ((lo_len == SH_SAT) ? lo_len : lo_len + 1'b1) : '0;
      rise_gap <= (alert && !a_d) ? TW'(1) : ((rise_gap == SH_SAT) ? rise_gap : rise_gap + 1'b1);
    end
  end

  AST_ALERT_MIN_ON:  assert property (@(posedge clk) disable iff (!rst_n) $fell(alert) |-> hi_len > ON_L);   // R4
  AST_ALERT_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n) $rose(alert) |-> lo_len > OFF_L);  // R5
  AST_REISSUE_GAP:   assert property (@(posedge clk) disable iff (!rst_n) $rose(alert) |-> rise_gap > RI_L); // R6
  AST_ALERT_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(alert) |-> $past(|chan_trip)); // R10
  AST_REJ_ONE_SHOT:  assert property (@(posedge clk) disable iff (!rst_n) $rose(rej_pulse) |-> $past(s_valid)); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_ast
    AST_STICKY_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n) $rose(chan_trip[c]) |-> chan_sticky[c]); // R9
  end
endmodule

// File: tb/test_temp_alert_cond.sv
module test_temp_alert_cond;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8, DW = 16, RCW = 8;
  localparam int MIN_ON = 12, MIN_OFF = 6, REISSUE = 40, STEP_LIM = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic [2:0] s_chan = '0;
  logic signed [DW-1:0] s_data = '0;
  logic [NCH*DW-1:0] trip_thr, clr_thr;
  logic [NCH-1:0] sticky_clr = '0;
  logic alert, rej_pulse;
  logic [NCH-1:0] chan_trip, chan_sticky;
  logic [NCH*RCW-1:0] rej_count;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_alert_cond #(.NCH(NCH), .DW(DW), .RCW(RCW), .MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF),
                    .REISSUE(REISSUE), .STEP_LIM(STEP_LIM)) i_temp_alert_cond (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_chan(s_chan),
    .s_data(s_data), .trip_thr(trip_thr), .clr_thr(clr_thr), .sticky_clr(sticky_clr),
    .alert(alert), .chan_trip(chan_trip), .chan_sticky(chan_sticky),
    .rej_pulse(rej_pulse), .rej_count(rej_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_thr(input int ch, input int tr, input int cl);
    trip_thr[ch*DW +: DW] = DW'(tr);
    clr_thr[ch*DW +: DW]  = DW'(cl);
  endtask

  task automatic send(input int ch, input int val);
    @(negedge clk);
    s_valid = 1'b1; s_chan = 3'(ch); s_data = DW'(val);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_al(input logic v, output int k);
    k = 0;
    while (alert !== v && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset;
    chk("R10 alert", alert, 0);
    chk("R10 chan_trip", chan_trip, 0);
    chk("R10 chan_sticky", chan_sticky, 0);
    chk("R10 rej_count", (rej_count == '0), 1);
    chk("R11 s_ready", s_ready, 1);
  endtask

  task automatic t_dwell_rate;
    int k, k2;
    send(0, 1300);
    wait_al(1'b1, k);
    chk("R10 alert latency", k, 2);
    set_thr(0, 1500, 1400);
    wait_al(1'b0, k);
    chk("R4 on dwell", k, MIN_ON + 1);
    set_thr(0, 1280, 1200);
    wait_al(1'b1, k2);
    chk("R6 reissue gap", k + k2, REISSUE + 1);
    settle(60);
    set_thr(0, 1500, 1400);
    wait_al(1'b0, k);
    chk("R4 late clear", k, 2);
    set_thr(0, 1280, 1200);
    wait_al(1'b1, k);
    chk("R5 off dwell", k, MIN_OFF + 1);
    set_thr(0, 1500, 1400);
    wait_al(1'b0, k);
  endtask

  task automatic t_partial;
    send(1, 1280);
    settle(2);
    chk("R2 R3 single sample at trip", chan_trip[1], 1);
  endtask

  task automatic t_average;
    send(2, 1200); settle(2); chk("R2 avg 1200", chan_trip[2], 0);
    send(2, 1260); settle(2); chk("R2 avg 1230", chan_trip[2], 0);
    send(2, 1320); settle(2); chk("R2 avg 1260", chan_trip[2], 0);
    send(2, 1380); settle(2); chk("R2 avg 1290", chan_trip[2], 1);
  endtask

  task automatic t_thresh;
    set_thr(3, 1000, 900);
    set_thr(4, 1500, 1400);
    send(3, 1200);
    send(4, 1200);
    settle(2);
    chk("R1 low trip level", chan_trip[3], 1);
    chk("R1 high trip level", chan_trip[4], 0);
  endtask

  task automatic t_hyst;
    send(5, 1300); settle(20);
    chk("R3 tripped", chan_trip[5], 1);
    send(5, 1250); settle(2); chk("R3 hold avg 1275", chan_trip[5], 1);
    send(5, 1150); settle(2); chk("R3 hold avg 1233", chan_trip[5], 1);
    send(5, 1100); settle(2); chk("R3 clear at level", chan_trip[5], 0);
  endtask

  task automatic t_min_on;
    send(6, 1300);
    send(6, 1150);
    send(6, 1000);
    settle(1);
    chk("R4 channel held", chan_trip[6], 1);
    settle(12);
    chk("R4 channel released", chan_trip[6], 0);
  endtask

  task automatic t_reject;
    set_thr(4, 1300, 1250);
    send(4, 1400);
    chk("R8 reject pulse", rej_pulse, 1);
    settle(2);
    chk("R8 count 1", rej_count[4*RCW +: RCW], 1);
    chk("R7 rejected not averaged", chan_trip[4], 0);
    chk("R8 pulse one cycle", rej_pulse, 0);
    send(4, 1360);
    settle(2);
    chk("R7 limit step accepted", rej_count[4*RCW +: RCW], 1);
    send(4, 1040);
    settle(2);
    chk("R7 negative step rejected", rej_count[4*RCW +: RCW], 2);
    chk("R8 other channel count", rej_count[3*RCW +: RCW], 0);
    set_thr(4, 1280, 1250);
    settle(2);
    chk("R7 avg of accepted only", chan_trip[4], 1);
  endtask

  task automatic t_sticky;
    chk("R9 sticky record", chan_sticky, 8'h7F);
    @(negedge clk); sticky_clr = 8'h08;
    @(negedge clk); sticky_clr = '0;
    chk("R9 sticky cleared", chan_sticky, 8'h77);
    chk("R9 trip kept", chan_trip[3], 1);
  endtask

  task automatic t_or;
    settle(100);
    chk("R10 alert from tripped channels", alert, 1);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) set_thr(c, 1280, 1200);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_dwell_rate;
    t_partial;
    t_average;
    t_thresh;
    t_hyst;
    t_min_on;
    t_reject;
    t_sticky;
    t_or;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule